// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Masked Half-Word Writes

This block is a register-mapped general-purpose I/O controller serving 118 pins spread over four banks of unequal size (32, 22, 32 and 32 pins). Software changes any subset of a bank's output bits in a single bus write, with no read-modify-write. Two masked-write registers per bank do this, one for each 16-pin half. Each of their words pairs a 16-bit keep-mask with 16 data bits. A full-width data register, per-pin direction and output-enable registers, a read-only synchronized input register and a write-one-to-set interrupt-mask register complete each bank.

The bus side is a plain 32-bit port. A write takes effect on the clock edge where `reg_wen` is high. Reads are combinational from `reg_addr`. The pin side presents one output value, one output-enable and one input per pin, numbered globally. It also presents each pin's interrupt mask state for downstream interrupt logic.

Top module: `gpio_mw_ctrl`

## Requirements
- R1: After reset every output data, direction and output-enable bit is 0, and every implemented interrupt mask bit is 1.
- R2: A write to the low masked register (offset 0x00) updates bank pin j (j < 16) with data bit j only where mask bit 16+j is 0. Pins whose mask bit is 1 keep their value.
- R3: A write to the high masked register (offset 0x04) applies the same rule to bank pins 16 to 31. Data bit j and mask bit 16+j govern pin 16+j.
- R4: Reading either masked register returns the current output data of its half in bits [15:0] and 0 in bits [31:16].
- R5: A write to the data register (offset 0x08) sets all outputs of the bank unconditionally, and reading it returns the outputs. Outputs change only on a mapped write.
- R6: Direction (offset 0x10) and output-enable (offset 0x14) are separate read/write bit vectors. A pin's `pin_oe` is 1 only when both of its bits are 1.
- R7: Writing 1 to a bit of the interrupt-disable register (offset 0x18) sets that pin's mask. Writing 0 has no effect, so mask bits never fall. The register reads back the mask.
- R8: Bank 1 has 22 pins. Its bits 22 to 31 read 0 in every register and ignore writes. Global pin numbers start at 0, 32, 54 and 86 for banks 0 to 3.
- R9: The input register (offset 0x0C) shows `pin_in` through a two-stage synchronizer. A change becomes readable after the second rising edge.
- R10: Offsets 0x1C to 0x3C of a bank read 0 and their writes are ignored. A write to the input register changes nothing.
- R11: A register's address is bank × 0x40 + offset. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 118 | Pin input levels |
| pin_out | output | 118 | Pin output values |
| pin_oe | output | 118 | Pin drive enables |
| irq_mask | output | 118 | Per-pin interrupt mask state |

## Verification
Some properties are checked on every cycle. Unmapped offsets return zero. Outputs and drive enables hold still without a mapped write. Mask bits never fall. Low-half pins under a set keep-mask bit hold through a masked write. The upper bits of the narrow bank read zero.

Some behaviour only the bench scenarios show. These are the exact merged values after masked writes in all four banks, the high-half bit alignment, the readback format and the global pin numbering. The bench also shows the two-edge input latency and the reset values.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 32;
  localparam int HALF_W    = BANK_W / 2;

  typedef enum logic [3:0] {
    RG_MLO  = 4'd0,
    RG_MHI  = 4'd1,
    RG_DATA = 4'd2,
    RG_IN   = 4'd3,
    RG_DIR  = 4'd4,
    RG_OEN  = 4'd5,
    RG_IDIS = 4'd6
  } reg_e;

  localparam logic [3:0] LAST_REG = 4'(RG_IDIS);

  function automatic int bank_pins(int b);
    return (b == 1) ? 22 : 32;
  endfunction

  function automatic int bank_base(int b);
    int s = 0;
    for (int i = 0; i < b; i++) s += bank_pins(i);
    return s;
  endfunction

  function automatic int total_pins();
    return bank_base(NUM_BANKS);
  endfunction

  function automatic logic [BANK_W-1:0] valid_bits(int p);
    logic [BANK_W-1:0] v = '0;
    for (int i = 0; i < BANK_W; i++) v[i] = (i < p);
    return v;
  endfunction

  // keep where mask=1, take data where mask=0
  function automatic logic [HALF_W-1:0] merge_half(logic [HALF_W-1:0] cur,
                                                   logic [BANK_W-1:0] w);
    return (cur & w[BANK_W-1:HALF_W]) | (w[HALF_W-1:0] & ~w[BANK_W-1:HALF_W]);
  endfunction

  function automatic logic [BANK_W-1:0] masked_word(logic [BANK_W-1:0] cur,
                                                    logic hi,
                                                    logic [BANK_W-1:0] w);
    logic [BANK_W-1:0] r = cur;
    if (hi) r[BANK_W-1:HALF_W] = merge_half(cur[BANK_W-1:HALF_W], w);
    else    r[HALF_W-1:0]      = merge_half(cur[HALF_W-1:0], w);
    return r;
  endfunction

endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        reg_idx,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] sync_in,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] oen_q,
  output logic [BANK_W-1:0] imask_q,
  output logic [BANK_W-1:0] rdata
);
  localparam logic [BANK_W-1:0] VMASK = valid_bits(PINS);

  // named next-state events
  logic wr_mlo, wr_mhi, wr_data, wr_dir, wr_oen, wr_idis;
  logic [BANK_W-1:0] out_nxt;

  always_comb begin
    wr_mlo  = wr_en && (reg_idx == 4'(RG_MLO));
    wr_mhi  = wr_en && (reg_idx == 4'(RG_MHI));
    wr_data = wr_en && (reg_idx == 4'(RG_DATA));
    wr_dir  = wr_en && (reg_idx == 4'(RG_DIR));
    wr_oen  = wr_en && (reg_idx == 4'(RG_OEN));
    wr_idis = wr_en && (reg_idx == 4'(RG_IDIS));
  end

  always_comb begin
    out_nxt = out_q;
    if (wr_mlo)       out_nxt = masked_word(out_q, 1'b0, wdata);
    else if (wr_mhi)  out_nxt = masked_word(out_q, 1'b1, wdata);
    else if (wr_data) out_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      oen_q   <= '0;
      imask_q <= VMASK;
    end else begin
      out_q <= out_nxt & VMASK;
      if (wr_dir)  dir_q   <= wdata & VMASK;
      if (wr_oen)  oen_q   <= wdata & VMASK;
      if (wr_idis) imask_q <= imask_q | (wdata & VMASK);
    end
  end

  always_comb begin
    case (reg_idx)
      4'(RG_MLO):  rdata = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
      4'(RG_MHI):  rdata = {{HALF_W{1'b0}}, out_q[BANK_W-1:HALF_W]};
      4'(RG_DATA): rdata = out_q;
      4'(RG_IN):   rdata = sync_in & VMASK;
      4'(RG_DIR):  rdata = dir_q;
      4'(RG_OEN):  rdata = oen_q;
      4'(RG_IDIS): rdata = imask_q;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mw_ctrl.sv
module gpio_mw_ctrl
  import gpio_mw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STRIDE_LG = 6,
  parameter int NPINS     = 118
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq_mask
);
  localparam int BANK_AW = ADDR_W - STRIDE_LG;
  localparam int IDX_W   = STRIDE_LG - 2;

  // decode events, named for the checker
  logic [BANK_AW-1:0] bank_sel;
  logic [IDX_W-1:0]   idx_raw;
  logic [3:0]         reg_idx;
  logic               addr_unmapped;
  logic               write_hit;

  assign bank_sel      = reg_addr[ADDR_W-1:STRIDE_LG];
  assign idx_raw       = reg_addr[STRIDE_LG-1:2];
  assign reg_idx       = 4'(idx_raw);
  assign addr_unmapped = (32'(idx_raw) > 32'(LAST_REG)) ||
                         (32'(bank_sel) >= 32'(NUM_BANKS));
  assign write_hit     = reg_wen && !addr_unmapped;

  logic [NPINS-1:0] in_sync;
  gpio_mw_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  logic [31:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int P = bank_pins(b);
    localparam int B = bank_base(b);

    logic [31:0] sin, oq, dq, eq, mq;
    logic        wen_b;

    always_comb begin
      sin = '0;
      sin[P-1:0] = in_sync[B +: P];
    end

    assign wen_b = write_hit && (32'(bank_sel) == b);

    gpio_mw_bank #(.PINS(P)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wen_b), .reg_idx(reg_idx),
      .wdata(reg_wdata), .sync_in(sin),
      .out_q(oq), .dir_q(dq), .oen_q(eq), .imask_q(mq),
      .rdata(bank_rd[b])
    );

    assign pin_out[B +: P]  = oq[P-1:0];
    assign pin_oe[B +: P]   = dq[P-1:0] & eq[P-1:0];
    assign irq_mask[B +: P] = mq[P-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (!addr_unmapped && 32'(bank_sel) == b) reg_rdata = bank_rd[b];
  end
endmodule

// File: rtl/gpio_mw_ctrl_chk.sv
module gpio_mw_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int NPINS  = 118
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  irq_mask,
  input logic              addr_unmapped,
  input logic              write_hit
);
  // R10
  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr_unmapped |-> reg_rdata == 32'h0);

  // R5
  a_r5_out_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !write_hit |=> $stable(pin_out));

  // R6
  a_r6_oe_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !write_hit |=> $stable(pin_oe));

  // R7
  a_r7_mask_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($past(irq_mask) & ~irq_mask) == '0);

  // R2: bank 0 low half, kept bits do not move
  a_r2_kept_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (write_hit && reg_addr[ADDR_W-1:2] == '0) |=>
      (pin_out[15:0] & $past(reg_wdata[31:16])) ==
      ($past(pin_out[15:0]) & $past(reg_wdata[31:16])));

  // R8: bank 1 data register upper bits read zero
  a_r8_narrow_bank_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] == 6'h12) |-> reg_rdata[31:22] == 10'h0);
endmodule

bind gpio_mw_ctrl gpio_mw_ctrl_chk #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_mask(irq_mask), .addr_unmapped(addr_unmapped), .write_hit(write_hit)
);

// File: tb/gpio_mw_ctrl_test.sv
module gpio_mw_ctrl_test;
  localparam int N = 118;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wen = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, irq_mask;

  int total = 0;
  int fails = 0;

  logic [N-1:0] e_out, e_dir, e_oen, e_msk;

  always #2.5 clk = ~clk;

  gpio_mw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_mask(irq_mask)
  );

  function automatic int bp(int b);
    return (b == 1) ? 22 : 32;
  endfunction

  function automatic int bb(int b);
    return 32 * b - ((b > 1) ? 10 : 0);
  endfunction

  function automatic logic [31:0] slice(logic [N-1:0] v, int b);
    logic [31:0] s = '0;
    for (int j = 0; j < bp(b); j++) s[j] = v[bb(b) + j];
    return s;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic model_wr(int b, int off, logic [31:0] d);
    for (int j = 0; j < bp(b); j++) begin
      int g = bb(b) + j;
      case (off)
        0:  if (j < 16 && !d[16 + j]) e_out[g] = d[j];
        4:  if (j >= 16 && !d[j]) e_out[g] = d[j - 16];
        8:  e_out[g] = d[j];
        16: e_dir[g] = d[j];
        20: e_oen[g] = d[j];
        24: if (d[j]) e_msk[g] = 1'b1;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_rd(int b, int off);
    case (off)
      0:  return {16'h0, slice(e_out, b) & 32'hFFFF};
      4:  return {16'h0, slice(e_out, b) >> 16};
      8:  return slice(e_out, b);
      16: return slice(e_dir, b);
      20: return slice(e_oen, b);
      24: return slice(e_msk, b);
      default: return 32'h0;
    endcase
  endfunction

  task automatic wrm(int b, int off, logic [31:0] d);
    wr(8'(b * 64 + off), d);
    model_wr(b, off, d);
  endtask

  task automatic check_pins(string tag);
    chk({tag, " pin_out"}, 128'(pin_out), 128'(e_out));
    chk({tag, " pin_oe"}, 128'(pin_oe), 128'(e_dir & e_oen));
    chk({tag, " irq_mask"}, 128'(irq_mask), 128'(e_msk));
  endtask

  task automatic check_rd(string tag, int b, int off);
    logic [31:0] v;
    rd(8'(b * 64 + off), v);
    chk(tag, 128'(v), 128'(exp_rd(b, off)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    e_out = '0; e_dir = '0; e_oen = '0; e_msk = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_pins("R1 reset");
    for (int b = 0; b < 4; b++) begin
      check_rd("R1 reset dir", b, 16);
      check_rd("R1 reset mask readback", b, 24);
    end

    // R11 / R8 global numbering: first pin of each bank
    for (int b = 0; b < 4; b++) begin
      wrm(b, 8, 32'h1);
      chk("R11 bank base pin", 128'(pin_out), 128'(e_out));
      chk("R8 base index", 128'(pin_out[bb(b)]), 128'(1'b1));
    end
    chk("R8 pins 0,32,54,86", 128'(pin_out),
        (128'(1) << 0) | (128'(1) << 32) | (128'(1) << 54) | (128'(1) << 86));
    for (int b = 0; b < 4; b++) wrm(b, 8, 32'h0);

    // R2 directed: full write through zero mask, then fully kept
    wrm(0, 0, 32'h0000_FFFF);
    chk("R2 all taken", 128'(pin_out[31:0]), 128'(32'h0000_FFFF));
    wrm(0, 0, 32'hFFFF_0000);
    chk("R2 all kept", 128'(pin_out[31:0]), 128'(32'h0000_FFFF));
    wrm(0, 4, 32'h00FF_A5A5);
    chk("R3 high half partial", 128'(pin_out[31:0]), 128'(32'hA500_FFFF));
    // address bits [1:0] ignored
    wr(8'h0B, 32'h1234_5678); model_wr(0, 8, 32'h1234_5678);
    chk("R11 low addr bits ignored", 128'(pin_out), 128'(e_out));

    // sweep all banks with arithmetic patterns
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] d;
        d = (32'(k) * 32'h9E37_79B9) ^ (32'(b) * 32'h0101_0101) ^ 32'h5A5A_A5A5;
        wrm(b, 0, d);
        check_pins("R2 masked low");
        check_rd("R4 low readback", b, 0);
        wrm(b, 4, d ^ 32'h0F0F_3333);
        check_pins("R3 masked high");
        check_rd("R4 high readback", b, 4);
        wrm(b, 16, d);
        wrm(b, 20, {d[15:0], d[31:16]});
        check_pins("R6 dir and oen");
        check_rd("R6 dir readback", b, 16);
        check_rd("R6 oen readback", b, 20);
        if (k[0]) begin
          wrm(b, 8, ~d);
          check_pins("R5 full data");
        end
        check_rd("R5 data readback", b, 8);
        if (b == 1) begin
          rd(8'h48, v);
          chk("R8 upper bits zero", 128'(v[31:22]), 128'(0));
        end
        wrm(b, 24, d & 32'h00FF_00FF);
        check_pins("R7 interrupt mask");
        check_rd("R7 mask readback", b, 24);
      end
    end

    // R7: writing zeros leaves the mask
    wrm(2, 24, 32'h0);
    chk("R7 zero write no effect", 128'(irq_mask), 128'(e_msk));

    // R10 unmapped offsets and input register are write-ignored
    for (int b = 0; b < 4; b++) begin
      for (int off = 28; off < 64; off += 4) begin
        wr(8'(b * 64 + off), 32'hFFFF_FFFF);
        check_rd("R10 unmapped reads zero", b, off);
      end
      wr(8'(b * 64 + 12), 32'hFFFF_FFFF);
    end
    check_pins("R10 no state change");

    // R9 two-stage input synchronizer
    for (int p = 0; p < 3; p++) begin
      logic [N-1:0] old_in, new_in;
      old_in = pin_in;
      new_in = {4{32'hC3A5_0F69 ^ 32'(p * 32'h1111_1111)}};
      @(negedge clk);
      reg_addr = 8'h0C;
      pin_in = new_in;
      @(negedge clk);
      #1 chk("R9 one edge still old", 128'(reg_rdata), 128'(slice(old_in, 0)));
      @(negedge clk);
      #1 chk("R9 two edges new", 128'(reg_rdata), 128'(slice(new_in, 0)));
      for (int b = 1; b < 4; b++) begin
        rd(8'(b * 64 + 12), v);
        chk("R9 bank input", 128'(v), 128'(slice(new_in, b)));
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule